// File: doc/BRIEF.md
# Single-Cycle Stack Pointer Unit

This block owns the stack pointer of a small stack machine and turns each push or pop into exactly one clock cycle of memory traffic. It has its own step adder, so the main ALU never touches the pointer. A push moves the pointer up before the write: the incremented value is on the address lines with the push data during the same cycle, and it is committed to the pointer at the closing edge. A pop reads at the current pointer and moves it down after the read: the memory word and the decremented pointer are both captured at the same closing edge.

Within one clock, the first phase is combinational. The request is decoded and the address, write data and strobes settle from the current pointer. The second phase is the rising edge, which updates the pointer, the captured pop word and the wrap flag together. The pointer can also be loaded from an external bus value. A load makes no memory access.

Top module: `sp_unit`

## Requirements
- R1: After reset the pointer is 0, the wrap flag is 0 and the captured pop word is 0.
- R2: In a push cycle the address output equals pointer+1, the write data equals the push input, write strobe is 1 and read strobe is 0, all within the same cycle.
- R3: At the edge closing a push cycle the pointer becomes its old value plus 1.
- R4: In a pop cycle the address output equals the current pointer, read strobe is 1 and write strobe is 0, within the same cycle.
- R5: At the edge closing a pop cycle the read data input is captured as the pop word and the pointer becomes its old value minus 1.
- R6: At the edge closing a load cycle the pointer takes the load value. During the load cycle both strobes are 0 and the address equals the current pointer.
- R7: Requests are resolved with load first, then push, then pop. A lower request that is present together with a higher one has no effect on the pointer, the strobes or the pop word.
- R8: With no request the pointer holds, both strobes are 0 and the address equals the pointer.
- R9: A push from all-ones wraps the pointer to 0, and a pop from 0 wraps it to all-ones. Either wrap sets the wrap flag, which stays set until reset, including across loads.
- R10: The pop word keeps its value in every cycle that is not a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge is the commit phase |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| load_req | input | 1 | Load the pointer from load_val |
| load_val | input | SP_W | Bus value for a load |
| push_data | input | DATA_W | Word to be pushed |
| mem_rdata | input | DATA_W | Memory read data |
| mem_addr | output | SP_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| pop_data | output | DATA_W | Last word captured by a pop |
| sp | output | SP_W | Current stack pointer |
| wrap_flag | output | 1 | Sticky wrap indicator |

## Verification
Push, pop and load requests can all arrive in the same cycle, and only one may win. The bench raises every pairing and the triple in one cycle each, from pointer values where the outcomes of the competing operations differ. It then judges the address and strobes inside that cycle and the pointer and pop word after the edge, against a priority model. The wrap cases combine a boundary pointer with a push or a pop, and then a load, to show that the flag stays set.

// File: rtl/sp_unit_pkg.sv
package sp_unit_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_LOAD = 2'd1,
      OP_PUSH = 2'd2,
      OP_POP  = 2'd3
   } sp_op_e;
endpackage

// File: rtl/sp_op_select.sv
module sp_op_select
   import sp_unit_pkg::*;
(
   input  logic   push_req,
   input  logic   pop_req,
   input  logic   load_req,
   output sp_op_e op
);
   always_comb begin
      if (load_req)      op = OP_LOAD;
      else if (push_req) op = OP_PUSH;
      else if (pop_req)  op = OP_POP;
      else               op = OP_IDLE;
   end
endmodule

// File: rtl/sp_step.sv
module sp_step #(
   parameter int SP_W  = 16,
   parameter bit SPLIT = 1'b1
) (
   input  logic [SP_W-1:0] cur,
   input  logic            up,
   output logic [SP_W-1:0] stepped,
   output logic            wraps
);
   localparam logic [SP_W-1:0] ONE  = {{(SP_W-1){1'b0}}, 1'b1};
   localparam logic [SP_W-1:0] ONES = {SP_W{1'b1}};

   generate
      if (SPLIT) begin : g_split
         logic [SP_W:0] inc_w;
         logic [SP_W:0] dec_w;
         assign inc_w   = {1'b0, cur} + {1'b0, ONE};
         assign dec_w   = {1'b0, cur} - {1'b0, ONE};
         assign stepped = up ? inc_w[SP_W-1:0] : dec_w[SP_W-1:0];
         assign wraps   = up ? inc_w[SP_W] : dec_w[SP_W];
      end else begin : g_shared
         logic [SP_W-1:0] addend;
         assign addend  = up ? ONE : ONES;
         assign stepped = cur + addend;
         assign wraps   = up ? (cur == ONES) : (cur == '0);
      end
   endgenerate
endmodule

// File: rtl/sp_state.sv
module sp_state
   import sp_unit_pkg::*;
#(
   parameter int SP_W   = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sp_op_e            op,
   input  logic [SP_W-1:0]   stepped,
   input  logic              step_wraps,
   input  logic [SP_W-1:0]   load_val,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [SP_W-1:0]   sp_q,
   output logic              wrap_q,
   output logic [DATA_W-1:0] pop_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q   <= '0;
         wrap_q <= 1'b0;
         pop_q  <= '0;
      end else begin
         unique case (op)
            OP_LOAD: sp_q <= load_val;
            OP_PUSH: begin
               sp_q <= stepped;
               if (step_wraps) wrap_q <= 1'b1;
            end
            OP_POP: begin
               sp_q  <= stepped;
               pop_q <= mem_rdata;
               if (step_wraps) wrap_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   p_push_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_PUSH |=> sp_q == $past(sp_q) + 1'b1);
   p_pop_decr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_POP |=> sp_q == $past(sp_q) - 1'b1);
   p_pop_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_POP |=> pop_q == $past(mem_rdata));
   p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_LOAD |=> sp_q == $past(load_val));
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_IDLE |=> $stable(sp_q));
   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |=> wrap_q);
   p_pop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      op != OP_POP |=> $stable(pop_q));
endmodule

// File: rtl/sp_unit.sv
module sp_unit
   import sp_unit_pkg::*;
#(
   parameter int SP_W        = 16,
   parameter int DATA_W      = 16,
   parameter bit SPLIT_STEP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic              load_req,
   input  logic [SP_W-1:0]   load_val,
   input  logic [DATA_W-1:0] push_data,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [SP_W-1:0]   mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   output logic [DATA_W-1:0] pop_data,
   output logic [SP_W-1:0]   sp,
   output logic              wrap_flag
);
   generate
      if (SP_W < 2 || SP_W > 64) begin : g_bad_sp_w
         $error("sp_unit: SP_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("sp_unit: DATA_W out of range");
      end
   endgenerate

   sp_op_e          op;
   logic [SP_W-1:0] stepped;
   logic            step_wraps;

   sp_op_select u_sel (
      .push_req (push_req),
      .pop_req  (pop_req),
      .load_req (load_req),
      .op       (op)
   );

   sp_step #(.SP_W(SP_W), .SPLIT(SPLIT_STEP)) u_step (
      .cur     (sp),
      .up      (op == OP_PUSH),
      .stepped (stepped),
      .wraps   (step_wraps)
   );

   sp_state #(.SP_W(SP_W), .DATA_W(DATA_W)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .stepped    (stepped),
      .step_wraps (step_wraps),
      .load_val   (load_val),
      .mem_rdata  (mem_rdata),
      .sp_q       (sp),
      .wrap_q     (wrap_flag),
      .pop_q      (pop_data)
   );

   // first phase: address and strobes settle from the current pointer
   assign mem_addr  = (op == OP_PUSH) ? stepped : sp;
   assign mem_wdata = push_data;
   assign mem_we    = (op == OP_PUSH);
   assign mem_re    = (op == OP_POP);

   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));
   p_load_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load_req |-> !mem_we && !mem_re);
   p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_addr == sp + 1'b1);
   p_pop_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> mem_addr == sp);
endmodule

// File: tb/tb_sp_unit.sv
module tb_sp_unit;
   localparam int CLK_PERIOD = 10;
   localparam int SP_W   = 16;
   localparam int DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              push_req, pop_req, load_req;
   logic [SP_W-1:0]   load_val;
   logic [DATA_W-1:0] push_data;
   logic [DATA_W-1:0] mem_rdata;
   logic [SP_W-1:0]   mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic              mem_we, mem_re;
   logic [DATA_W-1:0] pop_data;
   logic [SP_W-1:0]   sp;
   logic              wrap_flag;

   int checks = 0;
   int fails  = 0;

   logic [SP_W-1:0]   m_sp;
   logic              m_wrap;
   logic [DATA_W-1:0] m_pop;

   always #(CLK_PERIOD/2) clk = ~clk;

   // memory stand-in: read data is a fixed function of the address
   assign mem_rdata = mem_addr ^ 16'h5A3C;

   sp_unit #(.SP_W(SP_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
      .load_req(load_req), .load_val(load_val), .push_data(push_data),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_re(mem_re), .pop_data(pop_data), .sp(sp),
      .wrap_flag(wrap_flag)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one full cycle: drive, check first-phase outputs, check commit
   task automatic cyc(input logic p, input logic q, input logic l,
                      input logic [SP_W-1:0] lv, input logic [DATA_W-1:0] pd,
                      input string req);
      logic [SP_W-1:0] e_addr;
      logic e_we, e_re;
      @(negedge clk);
      push_req = p; pop_req = q; load_req = l; load_val = lv; push_data = pd;
      #1;
      e_we   = !l && p;
      e_re   = !l && !p && q;
      e_addr = e_we ? m_sp + 1'b1 : m_sp;
      chk(req, "mem_addr", 32'(mem_addr), 32'(e_addr));
      chk(req, "mem_we", 32'(mem_we), 32'(e_we));
      chk(req, "mem_re", 32'(mem_re), 32'(e_re));
      if (e_we) chk(req, "mem_wdata", 32'(mem_wdata), 32'(pd));
      if (l) m_sp = lv;
      else if (e_we) begin
         if (m_sp == '1) m_wrap = 1'b1;
         m_sp = m_sp + 1'b1;
      end else if (e_re) begin
         if (m_sp == '0) m_wrap = 1'b1;
         m_pop = m_sp ^ 16'h5A3C;
         m_sp  = m_sp - 1'b1;
      end
      @(posedge clk);
      #1;
      chk(req, "sp", 32'(sp), 32'(m_sp));
      chk(req, "wrap_flag", 32'(wrap_flag), 32'(m_wrap));
      chk(req, "pop_data", 32'(pop_data), 32'(m_pop));
   endtask

   task automatic t_reset;
      rst_n = 1'b0; push_req = 0; pop_req = 0; load_req = 0;
      load_val = '0; push_data = '0;
      repeat (2) @(posedge clk);
      #1;
      m_sp = '0; m_wrap = 1'b0; m_pop = '0;
      chk("R1", "sp", 32'(sp), 32'h0);
      chk("R1", "wrap_flag", 32'(wrap_flag), 32'h0);
      chk("R1", "pop_data", 32'(pop_data), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_push_pop;
      cyc(1, 0, 0, '0, 16'h1111, "R2/R3");
      cyc(1, 0, 0, '0, 16'hBEEF, "R2/R3");
      cyc(1, 0, 0, '0, 16'h0042, "R2/R3");
      cyc(0, 1, 0, '0, '0, "R4/R5");
      cyc(0, 1, 0, '0, '0, "R4/R5");
      cyc(1, 0, 0, '0, 16'hCAFE, "R2/R3");
      cyc(0, 1, 0, '0, '0, "R4/R5");
   endtask

   task automatic t_load_idle;
      cyc(0, 0, 1, 16'h1234, '0, "R6");
      cyc(0, 0, 0, '0, '0, "R8/R10");
      cyc(0, 0, 0, '0, '0, "R8/R10");
      cyc(1, 0, 0, '0, 16'h7777, "R10");
      cyc(0, 0, 1, 16'h00F0, '0, "R6/R10");
   endtask

   task automatic t_conflict;
      cyc(1, 1, 0, '0, 16'hA0A0, "R7 push>pop");
      cyc(0, 1, 1, 16'h0500, '0, "R7 load>pop");
      cyc(1, 0, 1, 16'h0800, 16'h1234, "R7 load>push");
      cyc(1, 1, 1, 16'h0C00, 16'h4321, "R7 load>all");
      cyc(0, 1, 0, '0, '0, "R7 pop alone");
   endtask

   task automatic t_wrap;
      cyc(0, 0, 1, 16'hFFFE, '0, "R9");
      cyc(1, 0, 0, '0, 16'h0001, "R9");
      chk("R9", "no wrap before max", 32'(wrap_flag), 32'h0);
      cyc(1, 0, 0, '0, 16'h0002, "R9 push wrap");
      chk("R9", "sp after push wrap", 32'(sp), 32'h0);
      cyc(0, 0, 1, 16'h0010, '0, "R9 sticky over load");
      cyc(0, 0, 0, '0, '0, "R9 sticky idle");
   endtask

   task automatic t_pop_wrap;
      t_reset();
      cyc(0, 1, 0, '0, '0, "R9 pop wrap");
      chk("R9", "sp after pop wrap", 32'(sp), 32'hFFFF);
      chk("R9", "flag after pop wrap", 32'(wrap_flag), 32'h1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_push_pop();
      t_load_idle();
      t_conflict();
      t_wrap();
      t_pop_wrap();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule